// File: doc/BRIEF.md
# Program Memory Fetch Controller

This block serves byte fetches for an 8-bit core whose program counter spans a 64 KB space. Each fetch address goes one of three ways. It can read a parameterised on-chip ROM that covers the bottom of the space. It can start a read cycle on a multiplexed external bus. Or it ends at once with an error when neither path can serve it. On the external bus, one 8-bit port (port A) carries the low address byte and then the returned data. A second port (port B) can supply the upper address lines, either four of them or eight. Three control pins frame each cycle: an active-low address strobe, an active-low data strobe and a read/write line.

The same fetch path also loads the program counter. On a vector request the block reads the two bytes of the chosen vector and issues one load of the counter. After reset it issues a load of address 12 without being asked. Ports A and B also work as ordinary data registers. Pins that the bus claims for address read back as ones, and software writes to them are dropped.

Top module: `pmem_bus_ctrl`

## Requirements
- R1: While reset is held, and afterwards until a register is written, `as_n` and `ds_n` are 1 and the mode register (select 2) and port A (select 0) read 0. In the first cycle after reset is released, `pc_load` pulses once with `pc_val` = 12.
- R2: A fetch with an address below `ROM_BYTES` completes in the cycle after it is accepted. `fetch_done` is 1, `fetch_err` is 0, no strobe is asserted, and `fetch_data` equals `addr[7:0] ^ addr[15:8] ^ ROM_SEED`.
- R3: An external fetch runs in this fixed sequence of cycles. First one cycle with `as_n` low, the address driven and `pa_oe` = 1. Then one cycle with `as_n` high and the address still driven. Then one turnaround cycle with `pa_oe` = 0. Then `DS_CYC` cycles with `ds_n` low and `rw` = 1. `pa_in` is sampled in the last data-strobe cycle and returned with `fetch_done` in the next cycle.
- R4: The mode register holds bus enable in bit 0 and the upper-address setting in bits 2:1. With the bus enabled, setting 01 drives `addr[11:8]` on `pb_out[3:0]` and the port B register on `pb_out[7:4]`, setting 10 or 11 drives `addr[15:8]` on all of `pb_out`, and setting 00 leaves `pb_out` as the register.
- R5: A fetch at or above `ROM_BYTES` while the bus is disabled completes in the next cycle with `fetch_err` = 1 and `fetch_data` = 0xFF, and no strobe is asserted.
- R6: With the bus enabled, port A reads back 0xFF, and port B reads 1 in each bit that is claimed for upper address.
- R7: With the bus enabled, writes to port A are dropped, and writes to port B leave the claimed bits unchanged while still updating the other bits.
- R8: A vector request with an index n from 0 to 5 reads the bytes at 2n (upper) and 2n+1 (lower) and then pulses `pc_load` once with `pc_val` = {byte(2n), byte(2n+1)}, without raising `fetch_done`. Indices 6 and 7 are ignored.
- R9: When built with the low region marked inaccessible, a fetch below `ROM_BYTES` completes in the next cycle with `fetch_err` = 1 and no strobe is asserted.
- R10: A request that arrives while `busy` is 1 is ignored. When a valid vector request and a fetch request arrive in the same cycle, only the vector is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch request, accepted when not busy |
| fetch_addr | input | 16 | Fetch byte address |
| fetch_done | output | 1 | One-cycle fetch completion |
| fetch_data | output | 8 | Fetched byte, valid with fetch_done |
| fetch_err | output | 1 | Fetch could not be served |
| vec_req | input | 1 | Vector load request |
| vec_idx | input | 3 | Vector number |
| pc_load | output | 1 | One-cycle program counter load strobe |
| pc_val | output | 16 | Program counter load value |
| busy | output | 1 | Controller cannot accept a request |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 port A, 1 port B, 2 mode |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_sel |
| pa_out | output | 8 | Port A pin drive: register or multiplexed address |
| pa_oe | output | 1 | Port A output enable |
| pa_in | input | 8 | Port A pin input, sampled as bus data |
| pb_out | output | 8 | Port B pin drive: register merged with upper address |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw | output | 1 | Read/write line, 1 for read |

## Verification
The bench builds the main instance with a 2 KB ROM, a seed of 0x5A and two data-strobe cycles. In this configuration both ROM boundary addresses and an external address in each upper-address setting can be reached in a few cycles, and the bench checks the strobe sequence cycle by cycle. A second instance is built with the low region marked inaccessible, so that the error path for low addresses can be exercised. A small bus responder in the bench latches the address when the address strobe rises and answers with a byte derived from that address. This lets the bench show that the upper address lines really reach the pins.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

    typedef enum logic [1:0] {
        ROM_INTERNAL = 2'd0,
        ROM_NONE     = 2'd1,
        ROM_HOLE     = 2'd2
    } rom_kind_e;

    typedef enum logic [2:0] {
        E_IDLE  = 3'd0,
        E_ADDR  = 3'd1,
        E_LATCH = 3'd2,
        E_TURN  = 3'd3,
        E_DATA  = 3'd4
    } xfer_st_e;

    typedef enum logic [2:0] {
        V_IDLE    = 3'd0,
        V_HI_ISS  = 3'd1,
        V_HI_WAIT = 3'd2,
        V_LO_ISS  = 3'd3,
        V_LO_WAIT = 3'd4
    } vec_st_e;

    typedef enum logic [1:0] {
        RT_ROM   = 2'd0,
        RT_EXT   = 2'd1,
        RT_FAULT = 2'd2
    } route_e;

    typedef struct packed {
        logic [1:0] hi_cfg;
        logic       ad_en;
    } mode_t;

    localparam logic [1:0]  SEL_PA   = 2'd0;
    localparam logic [1:0]  SEL_PB   = 2'd1;
    localparam logic [1:0]  SEL_MODE = 2'd2;
    localparam int          NUM_VEC  = 6;
    localparam logic [15:0] BOOT_PC  = 16'd12;
    localparam logic [7:0]  FAULT_BYTE = 8'hFF;

    function automatic logic [7:0] rom_byte(input logic [15:0] a, input logic [7:0] seed);
        return a[7:0] ^ a[15:8] ^ seed;
    endfunction

    function automatic logic [7:0] hi_mask(input logic [1:0] cfg);
        case (cfg)
            2'b00:   return 8'h00;
            2'b01:   return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/pmem_port_regs.sv
module pmem_port_regs
    import pmem_pkg::*;
#(
    parameter bit FORCE_BUS = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [1:0] sel,
    input  logic [7:0] wdata,
    output mode_t      mode_eff,
    output logic [7:0] pa_q,
    output logic [7:0] pb_q,
    output logic [7:0] addr_mask,
    output logic [7:0] rdata
);

    mode_t mode_q;

    always_comb begin
        mode_eff        = mode_q;
        mode_eff.ad_en  = mode_q.ad_en | FORCE_BUS;
        addr_mask       = mode_eff.ad_en ? hi_mask(mode_q.hi_cfg) : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            pa_q   <= '0;
            pb_q   <= '0;
        end else if (wr) begin
            case (sel)
                SEL_PA: begin
                    if (!mode_eff.ad_en) pa_q <= wdata;
                end
                SEL_PB:   pb_q   <= (pb_q & addr_mask) | (wdata & ~addr_mask);
                SEL_MODE: mode_q <= mode_t'(wdata[2:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_PA:   rdata = mode_eff.ad_en ? 8'hFF : pa_q;
            SEL_PB:   rdata = pb_q | addr_mask;
            SEL_MODE: rdata = {5'b0, mode_eff};
            default:  rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/pmem_xfer.sv
module pmem_xfer
    import pmem_pkg::*;
#(
    parameter int        ROM_BYTES = 2048,
    parameter rom_kind_e ROM_KIND  = ROM_INTERNAL,
    parameter logic [7:0] ROM_SEED = 8'h5A,
    parameter int        DS_CYC    = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic [15:0] addr,
    input  logic        ad_en,
    input  logic [7:0]  bus_in,
    output logic        idle,
    output logic        done,
    output logic        err,
    output logic [7:0]  data,
    output logic [15:0] addr_q,
    output logic        as_n,
    output logic        ds_n,
    output logic        drive
);

    localparam int CNT_W = (DS_CYC > 1) ? $clog2(DS_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DS_CYC - 1);

    xfer_st_e         st;
    logic [CNT_W-1:0] cnt;
    route_e           rt;
    logic             in_rom;

    always_comb begin
        in_rom = ({1'b0, addr} < 17'(ROM_BYTES));
        if (ROM_KIND == ROM_NONE)      rt = RT_EXT;
        else if (in_rom)               rt = (ROM_KIND == ROM_HOLE) ? RT_FAULT : RT_ROM;
        else                           rt = ad_en ? RT_EXT : RT_FAULT;
    end

    assign idle  = (st == E_IDLE);
    assign as_n  = (st != E_ADDR);
    assign ds_n  = (st != E_DATA);
    assign drive = (st != E_TURN) && (st != E_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= E_IDLE;
            cnt    <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
            data   <= '0;
            addr_q <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (st)
                E_IDLE: begin
                    if (req) begin
                        addr_q <= addr;
                        case (rt)
                            RT_ROM: begin
                                done <= 1'b1;
                                data <= rom_byte(addr, ROM_SEED);
                            end
                            RT_FAULT: begin
                                done <= 1'b1;
                                err  <= 1'b1;
                                data <= FAULT_BYTE;
                            end
                            default: st <= E_ADDR;
                        endcase
                    end
                end
                E_ADDR:  st <= E_LATCH;
                E_LATCH: st <= E_TURN;
                E_TURN: begin
                    st  <= E_DATA;
                    cnt <= '0;
                end
                E_DATA: begin
                    if (cnt == CNT_LAST) begin
                        data <= bus_in;
                        done <= 1'b1;
                        st   <= E_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= E_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pmem_vec_seq.sv
module pmem_vec_seq
    import pmem_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        vec_req,
    input  logic [2:0]  vec_idx,
    input  logic        eng_idle,
    input  logic        eng_done,
    input  logic [7:0]  eng_data,
    output logic        start,
    output logic        owns,
    output logic        eng_req,
    output logic [15:0] eng_addr,
    output logic        boot_pend,
    output logic        pc_load,
    output logic [15:0] pc_val
);

    vec_st_e    st;
    logic [2:0] idx_q;
    logic [7:0] hi_q;

    assign start    = vec_req && (int'(vec_idx) < NUM_VEC) && eng_idle
                      && (st == V_IDLE) && !boot_pend;
    assign owns     = (st != V_IDLE);
    assign eng_req  = (st == V_HI_ISS) || (st == V_LO_ISS);
    assign eng_addr = {12'b0, idx_q, (st == V_LO_ISS)};

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= V_IDLE;
            idx_q     <= '0;
            hi_q      <= '0;
            boot_pend <= 1'b1;
            pc_load   <= 1'b0;
            pc_val    <= '0;
        end else begin
            pc_load <= 1'b0;
            if (boot_pend) begin
                boot_pend <= 1'b0;
                pc_load   <= 1'b1;
                pc_val    <= BOOT_PC;
            end
            case (st)
                V_IDLE: begin
                    if (start) begin
                        idx_q <= vec_idx;
                        st    <= V_HI_ISS;
                    end
                end
                V_HI_ISS:  if (eng_idle) st <= V_HI_WAIT;
                V_HI_WAIT: begin
                    if (eng_done) begin
                        hi_q <= eng_data;
                        st   <= V_LO_ISS;
                    end
                end
                V_LO_ISS:  if (eng_idle) st <= V_LO_WAIT;
                V_LO_WAIT: begin
                    if (eng_done) begin
                        pc_val  <= {hi_q, eng_data};
                        pc_load <= 1'b1;
                        st      <= V_IDLE;
                    end
                end
                default: st <= V_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pmem_bus_ctrl.sv
module pmem_bus_ctrl
    import pmem_pkg::*;
#(
    parameter int         ROM_BYTES = 2048,
    parameter rom_kind_e  ROM_KIND  = ROM_INTERNAL,
    parameter logic [7:0] ROM_SEED  = 8'h5A,
    parameter int         DS_CYC    = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_req,
    input  logic [15:0] fetch_addr,
    output logic        fetch_done,
    output logic [7:0]  fetch_data,
    output logic        fetch_err,
    input  logic        vec_req,
    input  logic [2:0]  vec_idx,
    output logic        pc_load,
    output logic [15:0] pc_val,
    output logic        busy,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic [7:0]  pa_out,
    output logic        pa_oe,
    input  logic [7:0]  pa_in,
    output logic [7:0]  pb_out,
    output logic        as_n,
    output logic        ds_n,
    output logic        rw
);

    localparam bit FORCE_BUS = (ROM_KIND == ROM_NONE);

    mode_t       mode_eff;
    logic [7:0]  pa_q, pb_q, addr_mask;
    logic        e_req, e_idle, e_done, e_err, e_drive;
    logic [7:0]  e_data;
    logic [15:0] e_addr, addr_q;
    logic        v_start, v_owns, v_req, boot_pend;
    logic [15:0] v_addr;

    pmem_port_regs #(.FORCE_BUS(FORCE_BUS)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
        .mode_eff(mode_eff), .pa_q(pa_q), .pb_q(pb_q),
        .addr_mask(addr_mask), .rdata(reg_rdata)
    );

    pmem_vec_seq u_vec (
        .clk(clk), .rst(rst), .vec_req(vec_req), .vec_idx(vec_idx),
        .eng_idle(e_idle), .eng_done(e_done), .eng_data(e_data),
        .start(v_start), .owns(v_owns), .eng_req(v_req), .eng_addr(v_addr),
        .boot_pend(boot_pend), .pc_load(pc_load), .pc_val(pc_val)
    );

    assign e_req  = v_owns ? v_req  : (fetch_req && !v_start && !boot_pend);
    assign e_addr = v_owns ? v_addr : fetch_addr;

    pmem_xfer #(
        .ROM_BYTES(ROM_BYTES), .ROM_KIND(ROM_KIND),
        .ROM_SEED(ROM_SEED), .DS_CYC(DS_CYC)
    ) u_xfer (
        .clk(clk), .rst(rst), .req(e_req), .addr(e_addr),
        .ad_en(mode_eff.ad_en), .bus_in(pa_in),
        .idle(e_idle), .done(e_done), .err(e_err), .data(e_data),
        .addr_q(addr_q), .as_n(as_n), .ds_n(ds_n), .drive(e_drive)
    );

    assign fetch_done = e_done && !v_owns;
    assign fetch_err  = e_err  && !v_owns;
    assign fetch_data = e_data;
    assign busy       = !e_idle || v_owns || boot_pend;

    assign pa_out = mode_eff.ad_en ? addr_q[7:0] : pa_q;
    assign pa_oe  = mode_eff.ad_en ? e_drive : 1'b1;
    assign pb_out = (pb_q & ~addr_mask) | (addr_q[15:8] & addr_mask);
    assign rw     = 1'b1;

endmodule

// File: rtl/pmem_bus_ctrl_chk.sv
module pmem_bus_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       fetch_done,
    input logic       fetch_err,
    input logic [7:0] fetch_data,
    input logic       pc_load,
    input logic [7:0] pa_out,
    input logic       pa_oe,
    input logic       as_n,
    input logic       ds_n,
    input logic       rw
);

    AST_DS_BUS_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !ds_n |-> (as_n && !pa_oe && rw)); // R3

    AST_AS_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !as_n |=> as_n); // R3

    AST_DS_AFTER_TURN: assert property (@(posedge clk) disable iff (rst)
        $fell(ds_n) |-> ($past(as_n) && !$past(pa_oe))); // R3

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        !as_n |=> $stable(pa_out)); // R3

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        fetch_err |-> (fetch_done && as_n && ds_n && fetch_data == 8'hFF)); // R5

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        !(fetch_done && pc_load)); // R8

endmodule

bind pmem_bus_ctrl pmem_bus_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .fetch_done(fetch_done), .fetch_err(fetch_err),
    .fetch_data(fetch_data), .pc_load(pc_load), .pa_out(pa_out),
    .pa_oe(pa_oe), .as_n(as_n), .ds_n(ds_n), .rw(rw)
);

// File: tb/pmem_bus_ctrl_tb.sv
`timescale 1ns/1ps
module pmem_bus_ctrl_tb;
    import pmem_pkg::*;

    localparam int         DS_CYC = 2;
    localparam logic [7:0] SEED   = 8'h5A;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        fetch_done, fetch_err;
    logic [7:0]  fetch_data;
    logic        vec_req = 1'b0;
    logic [2:0]  vec_idx = '0;
    logic        pc_load, busy;
    logic [15:0] pc_val;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata, pa_out, pa_in, pb_out;
    logic        pa_oe, as_n, ds_n, rw;

    logic [15:0] lat_addr = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    pmem_bus_ctrl #(.ROM_BYTES(2048), .ROM_KIND(ROM_INTERNAL), .ROM_SEED(SEED), .DS_CYC(DS_CYC)) u_dut (
        .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_done(fetch_done), .fetch_data(fetch_data), .fetch_err(fetch_err),
        .vec_req(vec_req), .vec_idx(vec_idx), .pc_load(pc_load), .pc_val(pc_val),
        .busy(busy), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pa_out(pa_out), .pa_oe(pa_oe), .pa_in(pa_in),
        .pb_out(pb_out), .as_n(as_n), .ds_n(ds_n), .rw(rw)
    );

    logic        h_req = 1'b0;
    logic [15:0] h_addr = '0;
    logic        h_done, h_err, h_pc_load, h_busy, h_pa_oe, h_as_n, h_ds_n, h_rw;
    logic [7:0]  h_data, h_rdata, h_pa_out, h_pb_out;
    logic [15:0] h_pc_val;

    pmem_bus_ctrl #(.ROM_BYTES(2048), .ROM_KIND(ROM_HOLE), .ROM_SEED(SEED), .DS_CYC(DS_CYC)) u_dut_hole (
        .clk(clk), .rst(rst), .fetch_req(h_req), .fetch_addr(h_addr),
        .fetch_done(h_done), .fetch_data(h_data), .fetch_err(h_err),
        .vec_req(1'b0), .vec_idx(3'd0), .pc_load(h_pc_load), .pc_val(h_pc_val),
        .busy(h_busy), .reg_wr(1'b0), .reg_sel(2'd0), .reg_wdata(8'd0),
        .reg_rdata(h_rdata), .pa_out(h_pa_out), .pa_oe(h_pa_oe), .pa_in(8'h00),
        .pb_out(h_pb_out), .as_n(h_as_n), .ds_n(h_ds_n), .rw(h_rw)
    );

    function automatic logic [7:0] exp_rom(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ SEED;
    endfunction

    function automatic logic [7:0] ext_byte(input logic [15:0] a);
        return ~a[7:0] ^ a[15:8];
    endfunction

    // External memory model: latch address when the address strobe is released
    always @(posedge as_n) lat_addr = {pb_out, pa_out};
    assign pa_in = ds_n ? 8'h00 : ext_byte(lat_addr);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic issue_fetch(input logic [15:0] a);
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a;
        @(negedge clk);
        fetch_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(as_n && ds_n, "R1 strobes idle in reset", {as_n, ds_n}, 2'b11);
        reg_sel = SEL_MODE;
        #1 chk(reg_rdata == 8'h00, "R1 mode reset", reg_rdata, 8'h00);
        reg_sel = SEL_PA;
        #1 chk(reg_rdata == 8'h00, "R1 port A reset", reg_rdata, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        chk(pc_load == 1'b1, "R1 boot load", pc_load, 1);
        chk(pc_val == 16'd12, "R1 boot address", pc_val, 16'd12);
        @(negedge clk);
        chk(pc_load == 1'b0, "R1 boot load single", pc_load, 0);
        rd_reg(SEL_MODE, v);
        chk(v == 8'h00, "R1 mode after reset", v, 8'h00);
    endtask

    task automatic t_rom();
        logic [15:0] addrs [3] = '{16'h0000, 16'h07FF, 16'h0123};
        foreach (addrs[i]) begin
            issue_fetch(addrs[i]);
            chk(fetch_done && !fetch_err, "R2 rom done", {fetch_done, fetch_err}, 2'b10);
            chk(fetch_data == exp_rom(addrs[i]), "R2 rom data", fetch_data, exp_rom(addrs[i]));
            chk(as_n && ds_n, "R2 no strobes", {as_n, ds_n}, 2'b11);
        end
    endtask

    task automatic t_fault_nobus();
        issue_fetch(16'h0800);
        chk(fetch_done && fetch_err, "R5 bus off error", {fetch_done, fetch_err}, 2'b11);
        chk(fetch_data == 8'hFF, "R5 error byte", fetch_data, 8'hFF);
    endtask

    task automatic ext_cycle(input logic [15:0] a, input logic [7:0] exp_pb, input logic [7:0] exp_d);
        issue_fetch(a);
        chk(!as_n && pa_oe && ds_n, "R3 address phase", {as_n, pa_oe, ds_n}, 3'b011);
        chk(pa_out == a[7:0], "R3 low address on port A", pa_out, a[7:0]);
        chk(pb_out == exp_pb, "R4 upper address on port B", pb_out, exp_pb);
        @(negedge clk);
        chk(as_n && pa_oe && ds_n && pa_out == a[7:0], "R3 latch phase",
            {as_n, pa_oe, ds_n, pa_out}, {3'b111, a[7:0]});
        @(negedge clk);
        chk(!pa_oe && ds_n && as_n, "R3 turnaround", {as_n, pa_oe, ds_n}, 3'b101);
        for (int k = 0; k < DS_CYC; k++) begin
            @(negedge clk);
            chk(!ds_n && rw && !fetch_done, "R3 data strobe phase", {ds_n, rw, fetch_done}, 3'b010);
        end
        @(negedge clk);
        chk(fetch_done && !fetch_err && ds_n, "R3 done after strobe", {fetch_done, fetch_err, ds_n}, 3'b101);
        chk(fetch_data == exp_d, "R3 sampled data", fetch_data, exp_d);
    endtask

    task automatic t_ext_byte();
        wr_reg(SEL_MODE, 8'h05);
        ext_cycle(16'h1234, 8'h12, ext_byte(16'h1234));
    endtask

    task automatic t_ext_nibble();
        logic [7:0] v;
        wr_reg(SEL_MODE, 8'h00);
        wr_reg(SEL_PB, 8'hA5);
        wr_reg(SEL_MODE, 8'h03);
        rd_reg(SEL_PB, v);
        chk(v == 8'hAF, "R6 port B claimed bits read one", v, 8'hAF);
        wr_reg(SEL_PB, 8'h00);
        wr_reg(SEL_MODE, 8'h00);
        rd_reg(SEL_PB, v);
        chk(v == 8'h05, "R7 port B claimed bits kept", v, 8'h05);
        wr_reg(SEL_MODE, 8'h03);
        wr_reg(SEL_PB, 8'hA0);
        ext_cycle(16'h3C80, 8'hAC, ext_byte(16'hAC80));
        wr_reg(SEL_MODE, 8'h01);
        wr_reg(SEL_PB, 8'h77);
        ext_cycle(16'h5901, 8'h77, ext_byte(16'h7701));
    endtask

    task automatic t_porta();
        logic [7:0] v;
        wr_reg(SEL_MODE, 8'h00);
        wr_reg(SEL_PA, 8'h3C);
        rd_reg(SEL_PA, v);
        chk(v == 8'h3C, "R7 port A plain write", v, 8'h3C);
        chk(pa_out == 8'h3C && pa_oe, "R7 port A pins", {pa_oe, pa_out}, {1'b1, 8'h3C});
        wr_reg(SEL_MODE, 8'h01);
        rd_reg(SEL_PA, v);
        chk(v == 8'hFF, "R6 port A reads ones", v, 8'hFF);
        wr_reg(SEL_PA, 8'h11);
        wr_reg(SEL_MODE, 8'h00);
        rd_reg(SEL_PA, v);
        chk(v == 8'h3C, "R7 port A write dropped", v, 8'h3C);
    endtask

    task automatic t_vectors();
        for (int n = 0; n < 6; n++) begin
            logic [15:0] exp = {exp_rom(16'(2*n)), exp_rom(16'(2*n+1))};
            bit seen_load = 0, seen_done = 0;
            logic [15:0] got = '0;
            @(negedge clk);
            vec_req = 1'b1; vec_idx = 3'(n);
            @(negedge clk);
            vec_req = 1'b0;
            for (int c = 0; c < 30 && !seen_load; c++) begin
                if (fetch_done) seen_done = 1;
                if (pc_load) begin seen_load = 1; got = pc_val; end
                else @(negedge clk);
            end
            chk(seen_load, "R8 vector load", seen_load, 1);
            chk(got == exp, "R8 vector value", got, exp);
            chk(!seen_done, "R8 no fetch_done on vector", seen_done, 0);
        end
        begin
            bit seen = 0;
            @(negedge clk);
            vec_req = 1'b1; vec_idx = 3'd6;
            @(negedge clk);
            vec_req = 1'b0;
            for (int c = 0; c < 15; c++) begin
                if (pc_load || busy) seen = 1;
                @(negedge clk);
            end
            chk(!seen, "R8 index 6 ignored", seen, 0);
        end
    endtask

    task automatic t_busy();
        int dones = 0;
        logic [7:0] d = '0;
        bit seen_load = 0;
        wr_reg(SEL_MODE, 8'h05);
        issue_fetch(16'h4000);
        fetch_req = 1'b1; fetch_addr = 16'h0001;
        @(negedge clk);
        fetch_req = 1'b0;
        for (int c = 0; c < 20; c++) begin
            if (fetch_done) begin dones++; d = fetch_data; end
            @(negedge clk);
        end
        chk(dones == 1, "R10 request while busy ignored", dones, 1);
        chk(d == ext_byte(16'h4000), "R10 first request served", d, ext_byte(16'h4000));
        dones = 0;
        @(negedge clk);
        vec_req = 1'b1; vec_idx = 3'd2; fetch_req = 1'b1; fetch_addr = 16'h0002;
        @(negedge clk);
        vec_req = 1'b0; fetch_req = 1'b0;
        for (int c = 0; c < 30; c++) begin
            if (fetch_done) dones++;
            if (pc_load) seen_load = 1;
            @(negedge clk);
        end
        chk(seen_load && dones == 0, "R10 vector wins", {seen_load, 8'(dones)}, {1'b1, 8'd0});
    endtask

    task automatic t_hole();
        @(negedge clk);
        h_req = 1'b1; h_addr = 16'h0010;
        @(negedge clk);
        h_req = 1'b0;
        chk(h_done && h_err, "R9 low region inaccessible", {h_done, h_err}, 2'b11);
        chk(h_as_n && h_ds_n, "R9 no strobes", {h_as_n, h_ds_n}, 2'b11);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_rom();
        t_fault_nobus();
        t_porta();
        t_ext_byte();
        t_ext_nibble();
        wr_reg(SEL_MODE, 8'h00);
        t_vectors();
        t_busy();
        t_hole();
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule